// File: doc/BRIEF.md
# Two-Level Interrupt Aggregator

This block gathers event lines from a receive section and a transmit section and turns them into one active-low interrupt request. Every source in a section has a sticky status bit and an enable bit. Each section has a read-only summary bit, and that summary bit has its own enable at the section level. The interrupt request is gated by both layers of enables.

To find the cause of an interrupt, the host first reads the section summary register. It then reads the status register of the section that is flagged, and clears the bits it has handled by writing 1 to them. All registers sit on a small address and data port. A write takes effect on the clock edge. Read data is a combinational function of the address.

Register map (three-bit address, data of `DATA_W` bits):

| Address | Register | Access |
|---|---|---|
| 0 | Section summary: bit 0 is receive, bit 1 is transmit | read-only |
| 1 | Section enable: bit 0 is receive, bit 1 is transmit | read/write |
| 2 | Receive source status | write 1 to clear |
| 3 | Receive source enable | read/write |
| 4 | Transmit source status | write 1 to clear |
| 5 | Transmit source enable | read/write |

Top module: `irq_aggregator`

## Requirements
- R1: After reset, every status and enable bit is 0, `int_n` is 1, and all six addresses read 0.
- R2: A source status bit is set on the clock edge that follows a 0-to-1 change of its event input. An event held high sets the bit only once. The edge history is cleared to 0 by reset.
- R3: Writing 1 to a bit at address 2 or 4 clears that status bit, and writing 0 leaves the bit as it is. If a new rising edge arrives in the same cycle as the clear, the bit stays set.
- R4: A status bit stays set after its event input returns low, until the host clears it.
- R5: Addresses 1, 3 and 5 read back the value last written. At address 1, only bits 1:0 are kept and the upper bits read 0.
- R6: Address 0 reads bit 0 as the OR over receive sources of (status AND enable), and bit 1 as the same for transmit. Writes to address 0 have no effect.
- R7: `int_n` is 0 exactly when some summary bit is 1 and its section enable is 1. It follows the registers in the same cycle, without an extra register stage.
- R8: A source status bit is recorded whether or not its source enable is set. The enable only gates the summary bit.
- R9: Unused addresses 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_evt | input | NUM_SRC | Receive section event lines |
| tx_evt | input | NUM_SRC | Transmit section event lines |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data for `addr` |
| int_n | output | 1 | Interrupt request, active low |

## Verification
The hardest case to reach from the ports is a host clear that lands in the same cycle as a fresh rising edge on the same source. The bench reaches it by releasing an event line, then raising it again in the same vector that writes 1 to that status bit, and reading the bit back in the next step. A second hard case is an event line held high across a clear. For that, the stimulus keeps the line high, clears the bit, and confirms that the bit does not come back.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
   localparam int ADDR_W        = 3;
   localparam int NUM_SECT      = 2;
   localparam logic [ADDR_W-1:0] A_SUMMARY = 3'd0;
   localparam logic [ADDR_W-1:0] A_SECT_EN = 3'd1;
   // per-section status address = 2 + 2*section, enable address = 3 + 2*section
   localparam int SECT_BASE     = 2;
endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank #(
   parameter int NUM_SRC = 8,
   parameter logic [2:0] STAT_ADDR = 3'd2,
   parameter logic [2:0] EN_ADDR   = 3'd3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] evt,
   input  logic               wr_en,
   input  logic [2:0]         addr,
   input  logic [NUM_SRC-1:0] wr_data,
   output logic [NUM_SRC-1:0] status,
   output logic [NUM_SRC-1:0] enable,
   output logic               pending
);
   logic [NUM_SRC-1:0] evt_q;
   logic [NUM_SRC-1:0] rise;
   logic [NUM_SRC-1:0] clr;

   assign rise = evt & ~evt_q;
   assign clr  = (wr_en && addr == STAT_ADDR) ? wr_data : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         evt_q  <= '0;
         status <= '0;
         enable <= '0;
      end else begin
         evt_q  <= evt;
         status <= (status & ~clr) | rise;
         if (wr_en && addr == EN_ADDR) enable <= wr_data;
      end
   end

   assign pending = |(status & enable);

   // R2: every rising edge is recorded on the next edge
   a_r2_set_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
      ((evt & ~evt_q) != '0) |=> ((status & $past(evt & ~evt_q)) == $past(evt & ~evt_q)));
   // R4: set bits stay set unless the host writes 1 to them
   a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (status != '0) |=> ((status & $past(status & ~clr)) == $past(status & ~clr)));
   // R3: a cleared bit with no new edge goes to zero
   a_r3_w1c: assert property (@(posedge clk) disable iff (!rst_n)
      (clr != '0) |=> ((status & $past(clr & ~(evt & ~evt_q))) == '0));
endmodule

// File: rtl/irq_sect_level.sv
module irq_sect_level #(
   parameter int NUM_SECT = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_SECT-1:0] pending,
   input  logic                en_wr,
   input  logic [NUM_SECT-1:0] en_data,
   output logic [NUM_SECT-1:0] summary,
   output logic [NUM_SECT-1:0] sect_en,
   output logic                int_n
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sect_en <= '0;
      else if (en_wr) sect_en <= en_data;
   end

   assign summary = pending;
   assign int_n   = ~|(summary & sect_en);

   // R7: request only with some section enabled
   a_r7_needs_sect_en: assert property (@(posedge clk) disable iff (!rst_n)
      !int_n |-> (sect_en != '0));
   // R7: no summary bit, no request
   a_r7_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (pending == '0) |-> int_n);
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
   import irq_agg_pkg::*;
#(
   parameter int NUM_SRC = 8,
   parameter int DATA_W  = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] rx_evt,
   input  logic [NUM_SRC-1:0] tx_evt,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [DATA_W-1:0]  wr_data,
   output logic [DATA_W-1:0]  rd_data,
   output logic               int_n
);
   localparam int SRC_PAD  = DATA_W - NUM_SRC;
   localparam int SECT_PAD = DATA_W - NUM_SECT;

   if (NUM_SRC > DATA_W) begin : g_bad_width
      $error("NUM_SRC must not exceed DATA_W");
   end
   if (DATA_W <= NUM_SECT) begin : g_bad_data
      $error("DATA_W must exceed the section count");
   end

   logic [NUM_SECT-1:0][NUM_SRC-1:0] evt_all, stat_all, en_all;
   logic [NUM_SECT-1:0][DATA_W-1:0]  stat_w, en_w;
   logic [NUM_SECT-1:0]              pend, summary, sect_en;
   logic [DATA_W-1:0]                summary_w, sect_en_w;

   assign evt_all[0] = rx_evt;
   assign evt_all[1] = tx_evt;

   for (genvar g = 0; g < NUM_SECT; g++) begin : g_sect
      irq_src_bank #(
         .NUM_SRC  (NUM_SRC),
         .STAT_ADDR(3'(SECT_BASE + 2*g)),
         .EN_ADDR  (3'(SECT_BASE + 2*g + 1))
      ) u_bank (
         .clk    (clk),
         .rst_n  (rst_n),
         .evt    (evt_all[g]),
         .wr_en  (wr_en),
         .addr   (addr),
         .wr_data(wr_data[NUM_SRC-1:0]),
         .status (stat_all[g]),
         .enable (en_all[g]),
         .pending(pend[g])
      );
      if (SRC_PAD == 0) begin : g_full
         assign stat_w[g] = stat_all[g];
         assign en_w[g]   = en_all[g];
      end else begin : g_pad
         assign stat_w[g] = {{SRC_PAD{1'b0}}, stat_all[g]};
         assign en_w[g]   = {{SRC_PAD{1'b0}}, en_all[g]};
      end
      // R6: a section with nothing enabled pending shows no summary
      a_r6_summary_clear: assert property (@(posedge clk) disable iff (!rst_n)
         ((stat_all[g] & en_all[g]) == '0) |-> !summary[g]);
   end

   irq_sect_level #(.NUM_SECT(NUM_SECT)) u_sect (
      .clk    (clk),
      .rst_n  (rst_n),
      .pending(pend),
      .en_wr  (wr_en && addr == A_SECT_EN),
      .en_data(wr_data[NUM_SECT-1:0]),
      .summary(summary),
      .sect_en(sect_en),
      .int_n  (int_n)
   );

   assign summary_w = {{SECT_PAD{1'b0}}, summary};
   assign sect_en_w = {{SECT_PAD{1'b0}}, sect_en};

   always_comb begin
      case (addr)
         A_SUMMARY: rd_data = summary_w;
         A_SECT_EN: rd_data = sect_en_w;
         3'd2:      rd_data = stat_w[0];
         3'd3:      rd_data = en_w[0];
         3'd4:      rd_data = stat_w[1];
         3'd5:      rd_data = en_w[1];
         default:   rd_data = '0;
      endcase
   end

   // R9: unused addresses read zero
   a_r9_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (addr > 3'd5) |-> (rd_data == '0));
endmodule

// File: tb/tb_irq_aggregator.sv
module tb_irq_aggregator;
   logic       clk = 0;
   logic       rst_n = 0;
   logic [7:0] rx_evt = 0, tx_evt = 0, wr_data = 0;
   logic       wr_en = 0;
   logic [2:0] addr = 0;
   logic [7:0] rd_data;
   logic       int_n;
   int n_chk = 0, n_bad = 0;

   always #5 clk = ~clk;

   irq_aggregator dut (.clk(clk), .rst_n(rst_n), .rx_evt(rx_evt), .tx_evt(tx_evt),
      .wr_en(wr_en), .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .int_n(int_n));

   typedef struct packed {
      logic [7:0] rx; logic [7:0] tx; logic we; logic [2:0] wa;
      logic [7:0] wd; logic [2:0] ra; logic [7:0] exp_rd; logic exp_int;
   } vec_t;

   localparam int NV = 15;
   localparam vec_t VECS [NV] = '{
      '{8'h01, 8'h00, 1'b0, 3'd0, 8'h00, 3'd2, 8'h01, 1'b1}, // R2 R8
      '{8'h00, 8'h00, 1'b0, 3'd0, 8'h00, 3'd2, 8'h01, 1'b1}, // R4
      '{8'h00, 8'h00, 1'b1, 3'd3, 8'h01, 3'd0, 8'h01, 1'b1}, // R6
      '{8'h00, 8'h00, 1'b1, 3'd1, 8'h01, 3'd1, 8'h01, 1'b0}, // R5 R7
      '{8'h00, 8'h00, 1'b1, 3'd1, 8'hFF, 3'd1, 8'h03, 1'b0}, // R5
      '{8'h00, 8'h80, 1'b0, 3'd0, 8'h00, 3'd4, 8'h80, 1'b0}, // R2
      '{8'h00, 8'h80, 1'b1, 3'd2, 8'h01, 3'd2, 8'h00, 1'b1}, // R3
      '{8'h00, 8'h80, 1'b1, 3'd5, 8'h80, 3'd0, 8'h02, 1'b0}, // R6 R7
      '{8'h00, 8'h80, 1'b1, 3'd0, 8'h00, 3'd0, 8'h02, 1'b0}, // R6
      '{8'h00, 8'h80, 1'b1, 3'd4, 8'h00, 3'd4, 8'h80, 1'b0}, // R3
      '{8'h00, 8'h80, 1'b1, 3'd4, 8'h80, 3'd4, 8'h00, 1'b1}, // R2 R3
      '{8'h00, 8'h00, 1'b0, 3'd0, 8'h00, 3'd4, 8'h00, 1'b1}, // R2
      '{8'h00, 8'h80, 1'b1, 3'd4, 8'h80, 3'd4, 8'h80, 1'b0}, // R3
      '{8'h00, 8'h80, 1'b1, 3'd1, 8'h01, 3'd0, 8'h02, 1'b1}, // R7
      '{8'h00, 8'h80, 1'b0, 3'd0, 8'h00, 3'd6, 8'h00, 1'b1}  // R9
   };

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [2:0] a, input string req, input logic [7:0] exp);
      addr = a; wr_en = 0; #1;
      check(req, rd_data, exp);
   endtask

   initial begin : watchdog
      #500000;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (2) @(posedge clk);
      #2;
      for (int a = 0; a < 8; a++) rd(3'(a), "R1", 8'h00);
      check("R1 int_n", {7'd0, int_n}, 8'h01);
      @(negedge clk); rst_n = 1;
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         rx_evt = VECS[i].rx; tx_evt = VECS[i].tx;
         wr_en = VECS[i].we; addr = VECS[i].wa; wr_data = VECS[i].wd;
         @(posedge clk); #1;
         wr_en = 0; addr = VECS[i].ra; #2;
         check($sformatf("vector %0d rd", i), rd_data, VECS[i].exp_rd);
         check($sformatf("vector %0d int_n R7", i), {7'd0, int_n}, {7'd0, VECS[i].exp_int});
      end
      // R2 R8: many sources rising together, none enabled
      @(negedge clk); rx_evt = 8'hFF; tx_evt = 8'h00;
      @(posedge clk); #2;
      rd(3'd2, "R2 R8 multi", 8'hFF);
      // R1: reset mid-run clears everything
      @(negedge clk); rx_evt = 0; rst_n = 0; #2;
      rd(3'd2, "R1 rx stat", 8'h00);
      rd(3'd5, "R1 tx en", 8'h00);
      rd(3'd1, "R1 sect en", 8'h00);
      check("R1 int_n", {7'd0, int_n}, 8'h01);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule